// File: doc/BRIEF.md
# Row Drive Phase Timing Generator

This block sequences the drive waveform of one row of a 16-level gray-scale matrix display. It divides an incoming oscillator tick into a display clock, then counts display-clock positions across a programmable row period. Each row opens with a reset interval, continues with a first and a second pre-charge interval, and ends with a current-drive interval. The width of the drive interval comes from a gamma table indexed by the pixel's gray level.

The timing fields, the gamma table and the pixel level are all sampled together on the last display clock of a row, so a row always runs with one consistent setting. A pixel at level zero gets only the reset interval. Any interval that would run past the end of the row is cut off at the row boundary. A one-cycle strobe marks the final oscillator tick of every row.

Top module: `row_phase_gen`

## Requirements
- R1: A display-clock position lasts `cfg_div + 1` asserted `osc_tick` cycles (ratio 1 to 16). While `osc_tick` is low, the position and all outputs hold.
- R2: `ph_reset` is high for row positions 0 through `cfg_ph1_len`, which is `cfg_ph1_len + 1` positions.
- R3: For a nonzero level, `ph_pre1` is high for the next `cfg_ph2_len + 1` positions after the reset interval.
- R4: For a nonzero level, `ph_pre2` is high for the next `cfg_ph3_len` positions after the first pre-charge interval. A value of 0 removes this interval.
- R5: For a nonzero level n, `drive_en` is high for the next W positions after the second pre-charge interval. W is the 6-bit table entry for n, held in `cfg_gray_tbl[(n-1)*6 +: 6]`.
- R6: At level 0, only `ph_reset` is ever asserted in the row.
- R7: A row has `cfg_row_clks` positions, with values below 20 raised to 20. No interval extends past the last position. At most one phase output is high at a time, and all are low after the drive interval.
- R8: `row_done` is high for exactly one clock: the cycle with an accepted `osc_tick` that completes the last position of the row.
- R9: All configuration inputs and `pix_level` are sampled only at the row boundary. A change during a row first affects the following row.
- R10: During reset, and in the first row after reset, the timing is: divide by 1, reset interval 4, first pre-charge 6, no second pre-charge, drive width 0, 20 positions per row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick enable, one per oscillator period |
| cfg_div | input | 4 | Display clock divide ratio minus one |
| cfg_ph1_len | input | 4 | Reset interval length minus one |
| cfg_ph2_len | input | 4 | First pre-charge length minus one |
| cfg_ph3_len | input | 4 | Second pre-charge length (0 skips it) |
| cfg_row_clks | input | 7 | Display clocks per row (minimum 20 enforced) |
| cfg_gray_tbl | input | 90 | Drive widths for levels 1..15, 6 bits each, level 1 lowest |
| pix_level | input | 4 | Gray level of the pixel for the next row |
| ph_reset | output | 1 | Reset interval active |
| ph_pre1 | output | 1 | First pre-charge active |
| ph_pre2 | output | 1 | Second pre-charge active |
| drive_en | output | 1 | Current drive active |
| row_done | output | 1 | Last oscillator tick of the row |

## Verification
The bench goes after these cases:
- Level 0 against every other level. A design that ignored the zero check would pre-charge and drive dark pixels.
- A second pre-charge length of zero. An off-by-one there would insert or drop a position and shift the drive window.
- Gamma widths larger than the row. Without truncation, drive would leak into the next row's reset interval.
- Row lengths below the minimum. Without the clamp, the row period would collapse.
- Divide ratios up to 16, with stalls in the oscillator tick. A wrong divider or a missed hold shows up as drift in every phase edge and in the done strobe.

Each row's configuration is changed at the start of the previous row. A design that sampled the configuration mid-row would corrupt that row's pattern.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    localparam int DIV_W   = 4;
    localparam int PH_W    = 4;
    localparam int LEN_W   = 7;
    localparam int LVL_W   = 4;
    localparam int PW_W    = 6;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int TBL_W   = (NUM_LVL - 1) * PW_W;
    localparam int SUM_W   = LEN_W + 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RST,
        PH_PRE1,
        PH_PRE2,
        PH_DRV
    } phase_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PH_W-1:0]  ph1;
        logic [PH_W-1:0]  ph2;
        logic [PH_W-1:0]  ph3;
        logic [LEN_W-1:0] len;
        logic             lvl_nz;
        logic [PW_W-1:0]  width;
    } shadow_t;

    typedef struct packed {
        shadow_t          sh;
        logic [LEN_W-1:0] pos;
    } seq_state_t;
endpackage

// File: rtl/rpg_clk_div.sv
module rpg_clk_div
    import rpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [DIV_W-1:0] div_i,
    output logic             dclk_en
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        dclk_en = 1'b0;
        if (osc_tick) begin
            if (cnt_q == div_i) begin
                cnt_d   = '0;
                dclk_en = 1'b1;
            end else begin
                cnt_d = cnt_q + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_i);

    // R1
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(cnt_q));
endmodule

// File: rtl/rpg_lvl_lut.sv
module rpg_lvl_lut
    import rpg_pkg::*;
(
    input  logic [TBL_W-1:0] tbl_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [PW_W-1:0]  width_o,
    output logic             nz_o
);
    logic [PW_W-1:0] entry [NUM_LVL];

    assign entry[0] = '0;
    for (genvar gi = 1; gi < NUM_LVL; gi++) begin : g_entry
        assign entry[gi] = tbl_i[(gi-1)*PW_W +: PW_W];
    end

    assign width_o = entry[level_i];
    assign nz_o    = (level_i != '0);
endmodule

// File: rtl/rpg_phase_dec.sv
module rpg_phase_dec
    import rpg_pkg::*;
(
    input  logic [LEN_W-1:0] pos_i,
    input  shadow_t          sh_i,
    output phase_e           phase_o
);
    logic [SUM_W-1:0] p, end_rst, end_pre1, end_pre2, end_drv;

    always_comb begin
        p        = SUM_W'(pos_i);
        end_rst  = SUM_W'(sh_i.ph1) + SUM_W'(1);
        end_pre1 = end_rst + SUM_W'(sh_i.ph2) + SUM_W'(1);
        end_pre2 = end_pre1 + SUM_W'(sh_i.ph3);
        end_drv  = end_pre2 + SUM_W'(sh_i.width);
        if (p < end_rst)        phase_o = PH_RST;
        else if (!sh_i.lvl_nz)  phase_o = PH_IDLE;
        else if (p < end_pre1)  phase_o = PH_PRE1;
        else if (p < end_pre2)  phase_o = PH_PRE2;
        else if (p < end_drv)   phase_o = PH_DRV;
        else                    phase_o = PH_IDLE;
    end
endmodule

// File: rtl/row_phase_gen.sv
module row_phase_gen
    import rpg_pkg::*;
#(
    parameter int RST_PH1 = 3,
    parameter int RST_PH2 = 5,
    parameter int MIN_LEN = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [3:0]       cfg_div,
    input  logic [3:0]       cfg_ph1_len,
    input  logic [3:0]       cfg_ph2_len,
    input  logic [3:0]       cfg_ph3_len,
    input  logic [6:0]       cfg_row_clks,
    input  logic [89:0]      cfg_gray_tbl,
    input  logic [3:0]       pix_level,
    output logic             ph_reset,
    output logic             ph_pre1,
    output logic             ph_pre2,
    output logic             drive_en,
    output logic             row_done
);
    localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_LEN);

    seq_state_t      st_d, st_q;
    shadow_t         next_sh;
    logic            dclk_en;
    logic            last_pos;
    logic [PW_W-1:0] lut_width;
    logic            lut_nz;
    phase_e          phase;

    rpg_clk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .div_i    (st_q.sh.div),
        .dclk_en  (dclk_en)
    );

    rpg_lvl_lut u_lut (
        .tbl_i   (cfg_gray_tbl),
        .level_i (pix_level),
        .width_o (lut_width),
        .nz_o    (lut_nz)
    );

    rpg_phase_dec u_dec (
        .pos_i   (st_q.pos),
        .sh_i    (st_q.sh),
        .phase_o (phase)
    );

    always_comb begin
        next_sh.div    = cfg_div;
        next_sh.ph1    = cfg_ph1_len;
        next_sh.ph2    = cfg_ph2_len;
        next_sh.ph3    = cfg_ph3_len;
        next_sh.len    = (cfg_row_clks < LEN_FLOOR) ? LEN_FLOOR : cfg_row_clks;
        next_sh.lvl_nz = lut_nz;
        next_sh.width  = lut_width;

        last_pos = (st_q.pos == st_q.sh.len - LEN_W'(1));
        st_d     = st_q;
        row_done = 1'b0;
        if (dclk_en) begin
            if (last_pos) begin
                st_d.pos = '0;
                st_d.sh  = next_sh;
                row_done = 1'b1;
            end else begin
                st_d.pos = st_q.pos + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos       <= '0;
            st_q.sh.div    <= '0;
            st_q.sh.ph1    <= PH_W'(RST_PH1);
            st_q.sh.ph2    <= PH_W'(RST_PH2);
            st_q.sh.ph3    <= '0;
            st_q.sh.len    <= LEN_FLOOR;
            st_q.sh.lvl_nz <= 1'b1;
            st_q.sh.width  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_reset = (phase == PH_RST);
    assign ph_pre1  = (phase == PH_PRE1);
    assign ph_pre2  = (phase == PH_PRE2);
    assign drive_en = (phase == PH_DRV);

    // R8
    wrap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> (st_q.pos == '0));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_done |=> $stable(st_q.sh));

    // R7
    len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sh.len >= LEN_FLOOR);

    // R1
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dclk_en |=> $stable(st_q.pos));

    // R6
    gs0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.sh.lvl_nz |-> !(ph_pre1 || ph_pre2 || drive_en));

    // R2
    reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pos == '0) |-> ph_reset);

    // R7
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_reset, ph_pre1, ph_pre2, drive_en}));
endmodule

// File: tb/row_phase_gen_tb.sv
module row_phase_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic [3:0]  cfg_div = '0;
    logic [3:0]  cfg_ph1_len = '0;
    logic [3:0]  cfg_ph2_len = '0;
    logic [3:0]  cfg_ph3_len = '0;
    logic [6:0]  cfg_row_clks = 7'd20;
    logic [89:0] cfg_gray_tbl = '0;
    logic [3:0]  pix_level = '0;
    logic        ph_reset, ph_pre1, ph_pre2, drive_en, row_done;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int cur_div = 0, cur_a = 3, cur_b = 5, cur_c = 0, cur_len = 20, cur_nz = 1, cur_w = 0;

    always #2.5 clk = ~clk;

    row_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .cfg_div(cfg_div), .cfg_ph1_len(cfg_ph1_len), .cfg_ph2_len(cfg_ph2_len),
        .cfg_ph3_len(cfg_ph3_len), .cfg_row_clks(cfg_row_clks),
        .cfg_gray_tbl(cfg_gray_tbl), .pix_level(pix_level),
        .ph_reset(ph_reset), .ph_pre1(ph_pre1), .ph_pre2(ph_pre2),
        .drive_en(drive_en), .row_done(row_done)
    );

    function automatic int lutv(int n);
        return (n == 0) ? 0 : (n * 7 + 1) % 64;
    endfunction

    // 0 idle, 1 reset, 2 pre1, 3 pre2, 4 drive
    function automatic int exp_code(int p);
        int e1, e2, e3, e4;
        e1 = cur_a + 1;
        e2 = e1 + cur_b + 1;
        e3 = e2 + cur_c;
        e4 = e3 + cur_w;
        if (p < e1) return 1;
        if (cur_nz == 0) return 0;
        if (p < e2) return 2;
        if (p < e3) return 3;
        if (p < e4) return 4;
        return 0;
    endfunction

    function automatic int obs_code();
        int cnt;
        cnt = int'(ph_reset) + int'(ph_pre1) + int'(ph_pre2) + int'(drive_en);
        if (cnt > 1) return 9;
        if (ph_reset) return 1;
        if (ph_pre1)  return 2;
        if (ph_pre2)  return 3;
        if (drive_en) return 4;
        return 0;
    endfunction

    function automatic string tag_of(int code);
        case (code)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return (cur_nz == 0) ? "R6" : "R7";
        endcase
    endfunction

    task automatic chk_phase(int p, string why);
        int e, o;
        e = exp_code(p);
        o = obs_code();
        n_chk++;
        if (e != o) begin
            n_bad++;
            $display("FAIL %s %s pos=%0d phase actual=%0d expected=%0d", tag_of(e), why, p, o, e);
        end
    endtask

    task automatic chk_done(int exp, string tag);
        n_chk++;
        if (int'(row_done) != exp) begin
            n_bad++;
            $display("FAIL %s row_done actual=%0d expected=%0d", tag, row_done, exp);
        end
    endtask

    // Checks the current row; drives the next row's setting at its start (R9)
    task automatic do_row(int nd, int na, int nb, int nc, int nlen, int ngs, bit stall);
        cfg_div      = 4'(nd);
        cfg_ph1_len  = 4'(na);
        cfg_ph2_len  = 4'(nb);
        cfg_ph3_len  = 4'(nc);
        cfg_row_clks = 7'(nlen);
        pix_level    = 4'(ngs);
        for (int p = 0; p < cur_len; p++) begin
            for (int s = 0; s <= cur_div; s++) begin
                chk_phase(p, "R9 row");
                chk_done((p == cur_len - 1 && s == cur_div) ? 1 : 0, "R8");
                if (stall && p == 1 && s == 0) begin
                    osc_tick = 1'b0;
                    repeat (3) begin
                        @(negedge clk);
                        chk_phase(p, "R1 stall");
                        chk_done(0, "R1");
                    end
                    osc_tick = 1'b1;
                end
                @(negedge clk);
            end
        end
        cur_div = nd;
        cur_a   = na;
        cur_b   = nb;
        cur_c   = nc;
        cur_len = (nlen < 20) ? 20 : nlen;
        cur_nz  = (ngs != 0) ? 1 : 0;
        cur_w   = lutv(ngs);
    endtask

    initial begin
        for (int n = 1; n < 16; n++) cfg_gray_tbl[(n-1)*6 +: 6] = 6'(lutv(n));
        repeat (4) @(negedge clk);
        // R10: outputs during reset
        n_chk++;
        if (obs_code() != 1) begin
            n_bad++;
            $display("FAIL R10 reset phase actual=%0d expected=1", obs_code());
        end
        chk_done(0, "R10");
        rst_n = 1'b1;
        // first row runs on reset defaults (R10)
        do_row(0, 2, 1, 0, 20, 0, 1'b1);
        for (int i = 0; i < 32; i++) begin
            int ln, cc;
            case (i % 4)
                0: ln = 20;
                1: ln = 64;
                2: ln = 127;
                default: ln = 5;
            endcase
            cc = (i < 16) ? 0 : (i % 15) + 1;
            do_row(i % 3, (i * 3) % 16, (i * 5 + 2) % 16, cc, ln, i % 16, (i % 5) == 0);
        end
        do_row(15, 1, 0, 2, 20, 7, 1'b1);
        do_row(7, 0, 15, 15, 20, 15, 1'b0);
        do_row(0, 0, 0, 0, 20, 0, 1'b0);
        do_row(0, 0, 0, 0, 20, 0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule